// File: doc/BRIEF.md
# Supply-Event Store/Recall Controller

This block sequences the supply events of a nonvolatile SRAM model. Two synchronous comparator flags report the supply state: one is high while the supply is under the switch threshold, the other while it is under the lower reset threshold. When the supply falls through the switch threshold, the controller saves the SRAM contents to the nonvolatile array, but only if the SRAM has been written since the last save or restore. A dip under the reset threshold latches a restore. That restore is issued once the supply climbs back above the switch threshold. A shallow brown-out that never reaches the reset level does not trigger a restore.

The controller drives a one-cycle store request and a one-cycle recall request to the array. It drives a global access inhibit, and a pull-down enable for the open-drain busy line, which is low during a store. After every store or recall, it blocks writes if both the chip-enable and write strobes are already low. The block stays until either strobe makes a fresh falling edge. Save and restore durations, and the length of the busy probe pulse, are parameters in clock cycles.

The controller accepts two external store requests. A hardware pin request is honoured only when a write is pending. A software-sequence request is honoured unconditionally. Both are ignored while the supply is low or an operation is running. A strap disables the automatic save on power loss.

Top module: `pwr_event_ctrl`

## Requirements
- R1: Leaving reset, a recall is pending. With the supply above the switch level, `recall_req` pulses on the first clock edge. `access_inhibit` then stays high for `RECALL_CYC` cycles, counted from that edge, before it drops.
- R2: A rising edge of `below_switch` with a write pending and the strap low produces one `store_req` pulse. `busy_pull` stays high for exactly `STORE_CYC` consecutive cycles.
- R3: A rising edge of `below_switch` with no write since the last store or recall produces no `store_req`. `busy_pull` is high for exactly `PROBE_CYC` cycles.
- R4: With `auto_store_off` high, a supply drop produces neither `store_req` nor `busy_pull`.
- R5: `access_inhibit` is high whenever `below_switch` is high, and throughout every store, probe or recall.
- R6: `below_reset` going high latches a recall. `recall_req` pulses only after `below_switch` has returned low, and never while `below_switch` is high.
- R7: A dip of `below_switch` with `below_reset` staying low produces no `recall_req`. `access_inhibit` returns low.
- R8: `pin_store_req` starts a store only if a write is pending. `sw_store_req` starts a store regardless. Both are ignored while `below_switch` is high.
- R9: Starting a store or a recall clears the pending-write state. A following drop with no new write therefore only probes.
- R10: If `ce_n` and `we_n` are both 0 when a store or recall ends, `write_block` stays high until either strobe has a 1-to-0 transition. It then drops.
- R11: `store_req` and `recall_req` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| below_switch | input | 1 | Supply under the switch threshold |
| below_reset | input | 1 | Supply under the reset threshold |
| write_seen | input | 1 | An SRAM write completed this cycle |
| auto_store_off | input | 1 | Strap: disable the store on power loss |
| pin_store_req | input | 1 | Hardware pin store request (conditional) |
| sw_store_req | input | 1 | Software-sequence store request (unconditional) |
| ce_n | input | 1 | Chip-enable strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| store_req | output | 1 | One-cycle pulse: copy SRAM to nonvolatile array |
| recall_req | output | 1 | One-cycle pulse: clear SRAM, copy nonvolatile data in |
| access_inhibit | output | 1 | All reads and writes blocked |
| busy_pull | output | 1 | 1 drives the open-drain busy line low |
| write_block | output | 1 | SRAM writes blocked (inhibit or strobe lockout) |

## Verification
The bench drives a supply drop under four conditions: a write pending, no write pending, the strap set, and no write pending immediately after a store. These separate the real store from the probe-only busy pulse and from the strapped case. Separate dips, one through the reset level and one that stops above it, show whether a restore is latched only on a true reset. External requests are issued with and without a pending write, and while the supply is low. These separate the conditional pin path from the unconditional software path. A restore that ends with both strobes held low, followed by a strobe toggle, exercises the write lockout.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    PS_IDLE   = 3'd0,
    PS_STORE  = 3'd1,
    PS_PROBE  = 3'd2,
    PS_DOWN   = 3'd3,
    PS_RECALL = 3'd4
  } pe_state_t;
endpackage

// File: rtl/pe_timer.sv
module pe_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= len - W'(1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - W'(1);
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/pe_flags.sv
module pe_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic write_seen,
  input  logic below_reset,
  input  logic clr_dirty,
  input  logic clr_recall,
  output logic dirty,
  output logic recall_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty       <= 1'b0;
      recall_pend <= 1'b1;
    end else begin
      if (write_seen)     dirty <= 1'b1;
      else if (clr_dirty) dirty <= 1'b0;
      if (below_reset)     recall_pend <= 1'b1;
      else if (clr_recall) recall_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pe_wlock.sv
module pe_wlock (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic arm,
  output logic lock
);
  logic ce_q, we_q, fall;

  assign fall = (ce_q && !ce_n) || (we_q && !we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
      lock <= 1'b0;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
      if (arm)       lock <= !ce_n && !we_n;
      else if (fall) lock <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_event_ctrl.sv
module pwr_event_ctrl #(
  parameter int STORE_CYC  = 1000000,
  parameter int RECALL_CYC = 55000,
  parameter int PROBE_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_switch,
  input  logic below_reset,
  input  logic write_seen,
  input  logic auto_store_off,
  input  logic pin_store_req,
  input  logic sw_store_req,
  input  logic ce_n,
  input  logic we_n,
  output logic store_req,
  output logic recall_req,
  output logic access_inhibit,
  output logic busy_pull,
  output logic write_block
);
  import pe_pkg::*;

  localparam int MAXC = (STORE_CYC > RECALL_CYC) ?
                        ((STORE_CYC > PROBE_CYC) ? STORE_CYC : PROBE_CYC) :
                        ((RECALL_CYC > PROBE_CYC) ? RECALL_CYC : PROBE_CYC);
  localparam int TW = $clog2(MAXC + 1);

  pe_state_t state, state_nx;
  logic      sw_q, drop;
  logic      t_start, t_done;
  logic [TW-1:0] t_len;
  logic      dirty, recall_pend, lock;
  logic      to_store, to_recall, to_idle;

  assign drop = below_switch && !sw_q;

  always_comb begin
    state_nx = state;
    t_start  = 1'b0;
    t_len    = TW'(PROBE_CYC);
    unique case (state)
      PS_IDLE: begin
        if (below_switch) begin
          if (drop && !auto_store_off) begin
            t_start = 1'b1;
            if (dirty) begin
              state_nx = PS_STORE;
              t_len    = TW'(STORE_CYC);
            end else begin
              state_nx = PS_PROBE;
            end
          end else begin
            state_nx = PS_DOWN;
          end
        end else if (sw_store_req || (pin_store_req && dirty)) begin
          state_nx = PS_STORE;
          t_start  = 1'b1;
          t_len    = TW'(STORE_CYC);
        end
      end
      PS_STORE, PS_PROBE, PS_RECALL: begin
        if (t_done)
          state_nx = (below_switch || recall_pend) ? PS_DOWN : PS_IDLE;
      end
      PS_DOWN: begin
        if (!below_switch) begin
          if (recall_pend) begin
            state_nx = PS_RECALL;
            t_start  = 1'b1;
            t_len    = TW'(RECALL_CYC);
          end else begin
            state_nx = PS_IDLE;
          end
        end
      end
      default: state_nx = PS_DOWN;
    endcase
  end

  assign to_store  = (state_nx == PS_STORE)  && (state != PS_STORE);
  assign to_recall = (state_nx == PS_RECALL) && (state != PS_RECALL);
  assign to_idle   = (state_nx == PS_IDLE)   && (state != PS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_DOWN;
      sw_q       <= 1'b1;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      state      <= state_nx;
      sw_q       <= below_switch;
      store_req  <= to_store;
      recall_req <= to_recall;
    end
  end

  pe_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .done(t_done)
  );

  pe_flags u_flags (
    .clk(clk), .rst_n(rst_n), .write_seen(write_seen), .below_reset(below_reset),
    .clr_dirty(to_store || to_recall), .clr_recall(to_recall),
    .dirty(dirty), .recall_pend(recall_pend)
  );

  pe_wlock u_wlock (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .arm(to_idle), .lock(lock)
  );

  assign access_inhibit = (state != PS_IDLE) || below_switch;
  assign busy_pull      = (state == PS_STORE) || (state == PS_PROBE);
  assign write_block    = access_inhibit || lock;
endmodule

// File: rtl/pe_checker.sv
module pe_checker (
  input logic clk,
  input logic rst_n,
  input logic below_switch,
  input logic ce_n,
  input logic we_n,
  input logic store_req,
  input logic recall_req,
  input logic access_inhibit,
  input logic busy_pull,
  input logic write_block
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  a_r11_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  a_r11_recall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  a_r5_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    below_switch |-> access_inhibit);
  a_r2_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> (busy_pull && access_inhibit));
  a_r6_recall_supply_ok: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> !below_switch);
  a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (write_block && !access_inhibit && !ce_n && !we_n) |=> (ce_n || we_n || write_block));
endmodule

bind pwr_event_ctrl pe_checker i_pe_checker (
  .clk(clk), .rst_n(rst_n), .below_switch(below_switch), .ce_n(ce_n), .we_n(we_n),
  .store_req(store_req), .recall_req(recall_req), .access_inhibit(access_inhibit),
  .busy_pull(busy_pull), .write_block(write_block)
);

// File: tb/test_pwr_event_ctrl.sv
module test_pwr_event_ctrl;
  localparam int ST = 40;
  localparam int RC = 20;
  localparam int PR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below_switch = 1'b0, below_reset = 1'b0, write_seen = 1'b0;
  logic auto_store_off = 1'b0, pin_store_req = 1'b0, sw_store_req = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1;
  logic store_req, recall_req, access_inhibit, busy_pull, write_block;

  always #4 clk = ~clk;

  pwr_event_ctrl #(.STORE_CYC(ST), .RECALL_CYC(RC), .PROBE_CYC(PR)) i_pwr_event_ctrl (
    .clk(clk), .rst_n(rst_n), .below_switch(below_switch), .below_reset(below_reset),
    .write_seen(write_seen), .auto_store_off(auto_store_off),
    .pin_store_req(pin_store_req), .sw_store_req(sw_store_req),
    .ce_n(ce_n), .we_n(we_n), .store_req(store_req), .recall_req(recall_req),
    .access_inhibit(access_inhibit), .busy_pull(busy_pull), .write_block(write_block)
  );

  typedef struct { byte kind; int len; string req; } ev_t;
  ev_t exp_q[$];
  int checks = 0, errors = 0;
  int n_store = 0, n_recall = 0, run = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input byte k, input int l, input string req);
    ev_t e;
    e.kind = k; e.len = l; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(input byte k, input int l);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R11 unexpected event", int'(k), 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == k && e.len == l, e.req, int'(k) * 1000 + l, int'(e.kind) * 1000 + e.len);
    end
  endtask

  // monitor: scoreboard of store/recall pulses and busy run lengths
  always @(negedge clk) begin
    if (rst_n) begin
      if (store_req)  begin n_store++;  pop_cmp("S", 0); end
      if (recall_req) begin n_recall++; pop_cmp("R", 0); end
      if (busy_pull) run++;
      else if (run > 0) begin pop_cmp("B", run); run = 0; end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic wait_free(output int n);
    n = 0;
    do begin step(1); n++; end while (access_inhibit);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, s0, r0;
    step(2);
    chk(access_inhibit === 1'b1, "R5 inhibit in reset", access_inhibit, 1);
    chk(busy_pull === 1'b0, "R3 no busy in reset", busy_pull, 0);
    chk(store_req === 1'b0 && recall_req === 1'b0, "R11 idle pulses in reset", store_req, 0);

    // R1 power-up recall
    expect_ev("R", 0, "R1 power-up recall");
    rst_n = 1'b1;
    wait_free(n);
    chk(n == RC + 1, "R1 recall inhibit length", n, RC + 1);

    // R3 + R6 + R10: drop with no writes, reset dip, recall ends with strobes low
    expect_ev("B", PR, "R3 probe busy length");
    below_switch = 1'b1; step(1);
    below_reset = 1'b1; step(PR + 5);
    chk(access_inhibit === 1'b1, "R5 inhibit while low", access_inhibit, 1);
    chk(n_recall == 1, "R6 no recall while low", n_recall, 1);
    below_reset = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    step(3);
    expect_ev("R", 0, "R6 recall after reset dip");
    below_switch = 1'b0;
    wait_free(n);
    chk(n_recall == 2, "R6 recall count", n_recall, 2);
    step(3);
    chk(write_block === 1'b1, "R10 lock after recall", write_block, 1);
    we_n = 1'b1; step(1);
    chk(write_block === 1'b1, "R10 rising edge keeps lock", write_block, 1);
    we_n = 1'b0; step(1);
    chk(write_block === 1'b0, "R10 falling edge frees", write_block, 0);
    ce_n = 1'b1; we_n = 1'b1;

    // R7 brown-out without reset
    expect_ev("B", PR, "R7 brown-out probe");
    below_switch = 1'b1; step(PR + 4);
    below_switch = 1'b0; step(RC + 10);
    chk(n_recall == 2, "R7 no recall on brown-out", n_recall, 2);
    chk(access_inhibit === 1'b0, "R7 inhibit released", access_inhibit, 0);

    // R2 dirty store, then R9 probe only
    pulse(write_seen); step(2);
    expect_ev("S", 0, "R2 store on drop");
    expect_ev("B", ST, "R2 store busy length");
    below_switch = 1'b1; step(ST + 5);
    below_switch = 1'b0; step(4);
    chk(n_store == 1, "R2 store count", n_store, 1);
    expect_ev("B", PR, "R9 dirty cleared, probe only");
    below_switch = 1'b1; step(PR + 5);
    below_switch = 1'b0; step(4);
    chk(n_store == 1, "R9 no second store", n_store, 1);

    // R4 strap; R8 external requests ignored while low
    auto_store_off = 1'b1;
    pulse(write_seen); step(2);
    below_switch = 1'b1; step(3);
    chk(busy_pull === 1'b0, "R4 no busy with strap", busy_pull, 0);
    chk(access_inhibit === 1'b1, "R5 inhibit with strap", access_inhibit, 1);
    pulse(pin_store_req); pulse(sw_store_req); step(PR + 5);
    chk(n_store == 1, "R8 requests ignored while low", n_store, 1);
    below_switch = 1'b0; step(4);
    auto_store_off = 1'b0;
    chk(access_inhibit === 1'b0, "R4 released after strap drop", access_inhibit, 0);

    // R8 pin store with write pending, pin store without, software store
    expect_ev("S", 0, "R8 pin store dirty");
    expect_ev("B", ST, "R8 pin store busy");
    pulse(pin_store_req); step(ST + 4);
    s0 = n_store;
    chk(s0 == 2, "R8 pin store count", s0, 2);
    pulse(pin_store_req); step(10);
    chk(n_store == 2, "R8 pin store clean ignored", n_store, 2);
    chk(busy_pull === 1'b0, "R8 no busy on clean pin", busy_pull, 0);
    expect_ev("S", 0, "R8 software store clean");
    expect_ev("B", ST, "R8 software store busy");
    pulse(sw_store_req); step(ST + 4);
    chk(n_store == 3, "R8 software store count", n_store, 3);
    r0 = n_recall;
    chk(r0 == 2, "R11 total recall pulses", r0, 2);
    chk(exp_q.size() == 0, "R11 all expected events seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule